// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns bytes into an asynchronous serial bit stream on a single output line. A producer hands characters over through a one-entry holding register with a valid/ready handshake. A shifter takes each character out of that register and sends a start bit, then the data bits, an optional parity bit and a stop period. The character length, the parity, the stop period and the number of clock cycles per bit are all chosen at run time from plain configuration inputs. Each character takes the configuration that is present on the cycle it leaves the holding register.

Back-pressure works like this. `in_ready` is high only when the holding register is free and the transmitter is enabled. A byte is accepted on any rising clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is high and `in_ready` is low, the producer keeps `in_data` stable, and nothing is taken. The holding register frees up on the same edge that the shifter starts the character it holds. That edge ends the previous stop period when characters run back to back, so no idle gap appears between them.

A break control forces the line low for as long as it is asserted. `tx_empty` reports that neither the holding register nor the shifter has anything left to send.

Top module: `sertx_core`

## Requirements
- R1: With no character in flight and no break, the line stays high (mark). A character starts with one low start bit, and its data bits follow least significant bit first.
- R2: Length code `cfg_len` 00, 01, 10 and 11 selects 5, 6, 7 and 8 data bits. Only the low bits of `in_data` are sent.
- R3: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_even`=1 the data bits plus the parity bit hold an even number of ones, and with 0 they hold an odd number. When `cfg_par_en` is 0, no parity bit is sent.
- R4: Divisor code `cfg_div` 11 makes each bit last 64 clock cycles and 10 makes it last 16. Codes 01 and 00 make it last 1 cycle.
- R5: Stop code `cfg_stop` 11 gives a high stop period of 2 bit times and 10 gives 1.5 bit times. With the 1-cycle divisor, code 10 gives 2 cycles. Codes 01 and 00 give 1 bit time.
- R6: While `brk_req` is 1, the line is low in the same cycle. Character timing continues underneath the break.
- R7: `tx_empty` is 1 exactly when the holding register is free and no character is being shifted. This includes its stop period.
- R8: `in_ready` is 1 exactly when `tx_en` is 1 and the holding register is free. A byte is taken only on an edge where `in_valid` and `in_ready` are both 1. If `in_valid` is high while `in_ready` is low, nothing is taken.
- R9: While `tx_en` is 0, no new character starts. A character already being shifted finishes normally.
- R10: Configuration is sampled when a character starts, so a change in the middle of a character does not affect it. If the holding register is full when a stop period ends, the next start bit follows on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmitter enable |
| brk_req | input | 1 | Force the line low (break) |
| cfg_len | input | 2 | Data length code |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | Parity sense: 1 for even, 0 for odd |
| cfg_stop | input | 2 | Stop period code |
| cfg_div | input | 2 | Clock cycles per bit code |
| in_valid | input | 1 | Producer offers a byte |
| in_data | input | 8 | Offered byte |
| in_ready | output | 1 | Holding register free and transmitter enabled |
| tx_line | output | 1 | Serial output line |
| tx_empty | output | 1 | Nothing left to send |

## Verification
The embedded properties assume the producer follows the handshake. They assume `in_data` is stable whenever `in_valid` waits on a low `in_ready`. They also assume the configuration inputs are valid on the cycle a character starts. The stimulus only changes inputs at the falling clock edge. It offers each byte until the reference model reports that byte accepted, and drops `in_valid` right after. Changes to the configuration, `tx_en` and `brk_req` are deliberately placed in the middle of characters and while a byte waits in the holding register. This exercises the sampling and enable rules without breaking the handshake.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  typedef struct packed {
    logic [1:0] len;
    logic       par_en;
    logic       par_even;
    logic [1:0] stop;
    logic [1:0] div;
  } sertx_cfg_t;

  localparam int FRAME_W = 10;  // start + up to 8 data + parity
  localparam int SLOT_W  = 4;
endpackage

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          in_ready,
  output logic          full,
  output logic [DW-1:0] data
);
  logic accept;

  assign in_ready = tx_en && !full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      if (accept) begin
        full <= 1'b1;
        data <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
    end
  end

  // a rise of the full flag must come from a producer offer
  assert_fill_from_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full) |-> $past(in_valid));

  // a waiting byte is never altered
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> $stable(data));
endmodule

// File: rtl/sertx_frame.sv
module sertx_frame
  import sertx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64,
  parameter int CNT_W   = 8
) (
  input  sertx_cfg_t          cfg,
  input  logic [7:0]          data,
  output logic [FRAME_W-1:0]  frame,
  output logic [SLOT_W-1:0]   nslots,
  output logic [CNT_W-1:0]    bit_clk_m1,
  output logic [CNT_W-1:0]    stop_clk_m1
);
  int         len_n;
  int         per_bit;
  int         stop_n;
  logic [7:0] masked;
  logic       par_bit;

  always_comb begin
    len_n  = 5 + int'(cfg.len);
    masked = '0;
    for (int i = 0; i < 8; i++) begin
      if (i < len_n) masked[i] = data[i];
    end
    par_bit = cfg.par_even ? ^masked : ~^masked;

    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i < len_n) frame[1+i] = masked[i];
    end
    if (cfg.par_en) frame[1+len_n] = par_bit;

    nslots = SLOT_W'(1 + len_n + (cfg.par_en ? 1 : 0));

    case (cfg.div)
      2'b10:   per_bit = DIV_MID;
      2'b11:   per_bit = DIV_HI;
      default: per_bit = 1;
    endcase

    case (cfg.stop)
      2'b11:   stop_n = 2 * per_bit;
      2'b10:   stop_n = (per_bit == 1) ? 2 : per_bit + per_bit / 2;
      default: stop_n = per_bit;
    endcase

    bit_clk_m1  = CNT_W'(per_bit - 1);
    stop_clk_m1 = CNT_W'(stop_n - 1);
  end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               hold_full,
  input  logic [FRAME_W-1:0] frame,
  input  logic [SLOT_W-1:0]  nslots,
  input  logic [CNT_W-1:0]   bit_clk_m1,
  input  logic [CNT_W-1:0]   stop_clk_m1,
  output logic               take,
  output logic               busy,
  output logic               data_line
);
  logic [FRAME_W-1:0] sh;
  logic [SLOT_W-1:0]  slots;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   bit_q;
  logic [CNT_W-1:0]   stop_q;
  logic               done;

  assign done      = busy && slots == '0 && cnt == '0;
  assign take      = (!busy || done) && hold_full && tx_en;
  assign data_line = (busy && slots != '0) ? sh[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      sh     <= '1;
      slots  <= '0;
      cnt    <= '0;
      bit_q  <= '0;
      stop_q <= '0;
    end else if (take) begin
      busy   <= 1'b1;
      sh     <= frame;
      slots  <= nslots;
      cnt    <= bit_clk_m1;
      bit_q  <= bit_clk_m1;
      stop_q <= stop_clk_m1;
    end else if (busy) begin
      if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (slots > SLOT_W'(1)) begin
        sh    <= {1'b1, sh[FRAME_W-1:1]};
        slots <= slots - 1'b1;
        cnt   <= bit_q;
      end else if (slots == SLOT_W'(1)) begin
        slots <= '0;
        cnt   <= stop_q;
      end else begin
        busy <= 1'b0;
      end
    end
  end

  // a fresh character never begins while disabled
  assert_no_start_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(tx_en));

  // stop period always drives mark
  assert_stop_is_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && slots == '0) |-> data_line);
endmodule

// File: rtl/sertx_core.sv
module sertx_core
  import sertx_pkg::*;
#(
  parameter int DIV_MID = 16,
  parameter int DIV_HI  = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       brk_req,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic [1:0] cfg_stop,
  input  logic [1:0] cfg_div,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       tx_line,
  output logic       tx_empty
);
  localparam int CNT_W = $clog2(2 * DIV_HI);

  sertx_cfg_t         cfg;
  logic               hold_full;
  logic [7:0]         hold_data;
  logic               take;
  logic               busy;
  logic               data_line;
  logic [FRAME_W-1:0] frame;
  logic [SLOT_W-1:0]  nslots;
  logic [CNT_W-1:0]   bit_clk_m1;
  logic [CNT_W-1:0]   stop_clk_m1;

  assign cfg = '{len: cfg_len, par_en: cfg_par_en, par_even: cfg_par_even,
                 stop: cfg_stop, div: cfg_div};

  sertx_hold #(.DW(8)) hold_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .in_valid(in_valid),
    .in_data(in_data), .take(take), .in_ready(in_ready),
    .full(hold_full), .data(hold_data)
  );

  sertx_frame #(.DIV_MID(DIV_MID), .DIV_HI(DIV_HI), .CNT_W(CNT_W)) frame_i (
    .cfg(cfg), .data(hold_data), .frame(frame), .nslots(nslots),
    .bit_clk_m1(bit_clk_m1), .stop_clk_m1(stop_clk_m1)
  );

  sertx_shift #(.CNT_W(CNT_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .hold_full(hold_full),
    .frame(frame), .nslots(nslots), .bit_clk_m1(bit_clk_m1),
    .stop_clk_m1(stop_clk_m1), .take(take), .busy(busy),
    .data_line(data_line)
  );

  assign tx_line  = brk_req ? 1'b0 : data_line;
  assign tx_empty = !busy && !hold_full;

  assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |-> !tx_line);

  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && !brk_req) |-> tx_line);

  assert_empty_gives_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_empty && tx_en) |-> in_ready);

  assert_ready_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> tx_en);
endmodule

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b1;
  logic       brk_req = 1'b0;
  logic [1:0] cfg_len = 2'b11;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic [1:0] cfg_stop = 2'b01;
  logic [1:0] cfg_div = 2'b01;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       tx_line;
  logic       tx_empty;

  int    checks = 0;
  int    errors = 0;
  string tag = "R1";

  bit         wave[$];
  logic [7:0] hq[$];

  always #10 clk = ~clk;

  sertx_core dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .brk_req(brk_req),
    .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_even(cfg_par_even),
    .cfg_stop(cfg_stop), .cfg_div(cfg_div), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .tx_line(tx_line),
    .tx_empty(tx_empty)
  );

  function automatic bit exp_ready();
    return tx_en && hq.size() == 0;
  endfunction

  // behavioural waveform: one queue entry per clock cycle
  function automatic void build(logic [7:0] b);
    int nb, cyc, stopc, ones;
    nb  = 5 + int'(cfg_len);
    cyc = (cfg_div == 2'b11) ? 64 : (cfg_div == 2'b10) ? 16 : 1;
    if (cfg_stop == 2'b11) stopc = 2 * cyc;
    else if (cfg_stop == 2'b10) stopc = (cyc == 1) ? 2 : (3 * cyc) / 2;
    else stopc = cyc;
    ones = 0;
    repeat (cyc) wave.push_back(1'b0);
    for (int i = 0; i < nb; i++) begin
      if (b[i]) ones++;
      repeat (cyc) wave.push_back(b[i]);
    end
    if (cfg_par_en) begin
      bit p;
      p = cfg_par_even ? (ones % 2 == 1) : (ones % 2 == 0);
      repeat (cyc) wave.push_back(p);
    end
    repeat (stopc) wave.push_back(1'b1);
  endfunction

  task automatic check_bit(string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %b expected %b at %0t", tag, what, got, exp, $time);
    end
  endtask

  // inputs were set at the falling edge; compare, advance model, wait
  task automatic step();
    bit acc;
    #1;
    check_bit("tx_line", tx_line, brk_req ? 1'b0 : (wave.size() != 0 ? wave[0] : 1'b1));
    check_bit("in_ready", in_ready, exp_ready());
    check_bit("tx_empty", tx_empty, wave.size() == 0 && hq.size() == 0);
    acc = in_valid && exp_ready();
    if (wave.size() != 0) void'(wave.pop_front());
    if (wave.size() == 0 && hq.size() != 0 && tx_en) build(hq.pop_front());
    if (acc) hq.push_back(in_data);
    @(negedge clk);
  endtask

  task automatic offer(logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    for (int n = 0; n < 5000; n++) begin
      if (exp_ready()) begin
        step();
        in_valid = 1'b0;
        return;
      end
      step();
    end
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int n = 0; n < 5000; n++) begin
      if (wave.size() == 0 && hq.size() == 0) return;
      step();
    end
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired, run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state: mark line, ready, empty (R1, R7)
    tag = "R1_R7_reset";
    idle(3);

    // 8 data bits, no parity, back to back (R1, R10)
    tag = "R1_R10_b2b";
    offer(8'hA5);
    offer(8'h3C);
    offer(8'h01);
    drain();
    idle(2);

    // every length with every parity setting (R2, R3)
    for (int l = 0; l < 4; l++) begin
      for (int p = 0; p < 3; p++) begin
        tag = "R2_R3_len_par";
        cfg_len      = 2'(l);
        cfg_par_en   = (p != 0);
        cfg_par_even = (p == 2);
        offer(8'hD6);
        offer(8'h29);
        drain();
      end
    end

    // stop periods at 1x, including 1.5 treated as 2 (R5)
    cfg_par_en = 1'b0;
    cfg_len    = 2'b11;
    for (int s = 0; s < 4; s++) begin
      tag = "R5_stop_1x";
      cfg_stop = 2'(s);
      offer(8'h80);
      offer(8'h7F);
      drain();
    end

    // divisor 16 with 1.5 stop, divisor 64 with 2 stop (R4, R5)
    tag = "R4_R5_div16";
    cfg_div  = 2'b10;
    cfg_stop = 2'b10;
    offer(8'h5A);
    drain();
    tag = "R4_R5_div64";
    cfg_div  = 2'b11;
    cfg_stop = 2'b11;
    cfg_par_en = 1'b1;
    offer(8'hC3);
    drain();
    tag = "R4_code00";
    cfg_div  = 2'b00;
    cfg_stop = 2'b01;
    offer(8'h96);
    drain();

    // disable with a byte waiting: current finishes, next does not start (R9)
    tag = "R9_disable";
    cfg_div = 2'b10;
    cfg_par_en = 1'b0;
    offer(8'h11);
    offer(8'h22);
    idle(20);
    tx_en = 1'b0;
    idle(250);
    in_valid = 1'b1;  // offered while not ready: ignored (R8)
    in_data  = 8'h22;
    tag = "R8_R9_blocked";
    idle(10);
    in_valid = 1'b0;
    tx_en = 1'b1;
    tag = "R9_reenable";
    drain();

    // break in mid character and at idle (R6)
    tag = "R6_break";
    cfg_div = 2'b01;
    offer(8'hFF);
    brk_req = 1'b1;
    idle(6);
    brk_req = 1'b0;
    drain();
    brk_req = 1'b1;
    idle(5);
    brk_req = 1'b0;
    idle(2);

    // configuration change mid character (R10)
    tag = "R10_cfg_sample";
    cfg_div = 2'b10;
    offer(8'h4D);
    idle(40);
    cfg_len    = 2'b00;
    cfg_par_en = 1'b1;
    cfg_div    = 2'b01;
    drain();
    offer(8'h4D);
    drain();
    idle(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule